// File: doc/BRIEF.md
# Programmable Serial Transmitter

This block turns bytes into a serial bit stream. A host places one byte at a time into a single-entry holding buffer. When the shifter is free and sending is allowed, the byte moves into the shifter and goes out on `txd`, least significant bit first. Two framing styles share the same shifter:

- **Asynchronous framing** wraps each character in a low start bit, an optional parity bit and one, one-and-a-half or two high stop bits.
- **Synchronous framing** sends bare characters, plus parity, at one bit per transmit-clock period. When no data is waiting, it fills the gaps with the programmed sync characters.

The transmit clock arrives as `txc_fall`. It is a one-cycle enable in the master clock domain that marks each falling edge of the transmit clock. Every change on `txd` happens in a cycle where this enable is high. The exception is `brk`, which drives the idle line straight away. Two status outputs are provided. `tx_rdy` says the holding buffer can take a byte. `tx_empty` says no data character is buffered or being shifted.

Top module: `ser_tx_engine`

## Requirements
- R1: After reset, `txd` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: The `rate_sel` code sets how many ticks of `txc_fall` each bit lasts: 01 gives 1, 10 gives 16 and 11 gives 64. A non-zero code selects asynchronous framing: a 0 start bit, then the data bits LSB first, then the stop bits at 1. The `wlen_sel` code sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: When `par_en` is 1, a parity bit follows the last data bit. It is chosen so that the data bits plus the parity bit hold an odd number of ones when `par_even` is 0, and an even number when `par_even` is 1. When `par_en` is 0, no parity bit is sent.
- R4: The `stop_sel` code sets the stop bits:
  - 01 gives one full stop bit; 00 is treated the same way.
  - 11 gives two full stop bits.
  - 10 gives one full stop bit followed by a half-length one, lasting 8 ticks at rate 10 and 32 ticks at rate 11. At rate 01, code 10 gives two stop bits.
- R5: If the shifter is empty, a written byte moves into it on the next clock, and its first bit appears at the next tick. A byte already waiting in the buffer starts on the tick that ends the last bit of the current character, with no idle gap.
- R6: `tx_rdy` goes low in the cycle after a write is accepted and stays low until the byte moves into the shifter. `tx_empty` is low from that write until the last bit of the last data character has ended. `tx_empty` implies `tx_rdy`.
- R7: A write while `tx_rdy` is 0 is ignored: the byte is never sent.
- R8: No character starts while `cts_n` is 1 or `tx_en` is 0. `txd` then stays 1, and the buffered byte is kept until sending is allowed again.
- R9: While `brk` is 1, no new character starts and the idle line is driven to 0. A character already in the shifter is completed first, and a buffered byte waits.
- R10: A `rate_sel` of 00 selects synchronous framing: one tick per bit, with no start or stop bits, and with parity appended as in R3.
- R11: In synchronous framing, when sending is allowed and the buffer is empty at a character boundary, the block sends `sync1` and then `sync2`, or only `sync1` when `single_sync` is 1. While only sync characters are being sent, `tx_empty` stays 1.
- R12: `txd` changes only after a clock edge at which `txc_fall` was 1, or when `brk` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txc_fall | input | 1 | One-cycle enable marking a falling edge of the transmit clock |
| rate_sel | input | 2 | 00 synchronous; 01, 10 and 11 asynchronous at 1, 16 or 64 ticks per bit |
| wlen_sel | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit appended when 1 |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| stop_sel | input | 2 | Stop bit code (see R4) |
| single_sync | input | 1 | Fill with `sync1` only |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| brk | input | 1 | Hold the line low at character boundaries |
| sync1 | input | 8 | First fill character |
| sync2 | input | 8 | Second fill character |
| wr_stb | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to buffer |
| txd | output | 1 | Serial output |
| tx_rdy | output | 1 | Holding buffer free |
| tx_empty | output | 1 | No data character buffered or in flight |

## Verification
The bench builds the block with its default dividers of 16 and 64 and raises `txc_fall` on every fourth clock. As a result, the 8-tick and 32-tick half stop bits and a full 64-tick frame all fit within a short run, alongside 1-tick asynchronous and synchronous bits. Expected tick-by-tick line levels are queued by the driver and compared by a monitor. This covers back-to-back continuity, sync fill order in both the one-character and two-character variants, and the line held low by a break.

// File: rtl/ser_tx_engine.sv
module ser_tx_engine #(
  parameter int MID_DIV  = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txc_fall,
  input  logic [1:0] rate_sel,
  input  logic [1:0] wlen_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic [1:0] stop_sel,
  input  logic       single_sync,
  input  logic       tx_en,
  input  logic       cts_n,
  input  logic       brk,
  input  logic [7:0] sync1,
  input  logic [7:0] sync2,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_empty
);

  localparam int CW = $clog2(SLOW_DIV);
  localparam int FW = 12;

  logic          buf_full;
  logic [7:0]    buf_q;
  logic          sh_full, run, sh_fill, sync2_due, half_last;
  logic [FW-1:0] frm;
  logic [3:0]    slots_left;
  logic [CW-1:0] cnt, per_m1, half_m1;

  logic          sync_mode, can_go, take_fill, take_data, nxt_ok;
  logic [7:0]    nxt_byte, dm;
  logic          par_bit, nhalf;
  logic [FW-1:0] nf;
  logic [3:0]    k, nslots;
  logic          slot_end, last_slot, do_load;

  assign sync_mode = (rate_sel == 2'b00);
  assign can_go    = tx_en & ~cts_n & ~brk;
  assign take_fill = sync_mode & can_go & (sync2_due | ~buf_full);
  assign take_data = can_go & buf_full & ~take_fill;
  assign nxt_ok    = take_fill | take_data;
  assign nxt_byte  = take_fill ? (sync2_due ? sync2 : sync1) : buf_q;

  always_comb begin
    case (rate_sel)
      2'b10:   per_m1 = CW'(MID_DIV - 1);
      2'b11:   per_m1 = CW'(SLOW_DIV - 1);
      default: per_m1 = '0;
    endcase
    half_m1 = per_m1 >> 1;
  end

  always_comb begin
    dm      = nxt_byte & (8'hFF >> (2'd3 - wlen_sel));
    par_bit = (^dm) ^ ~par_even;
    nf      = '1;
    k       = 4'd0;
    if (!sync_mode) begin
      nf[0] = 1'b0;
      k     = 4'd1;
    end
    for (int i = 0; i < 8; i++) begin
      if (i < 5 + int'(wlen_sel)) begin
        nf[k] = dm[i];
        k     = k + 4'd1;
      end
    end
    if (par_en) begin
      nf[k] = par_bit;
      k     = k + 4'd1;
    end
    if (!sync_mode) k = k + (stop_sel[1] ? 4'd2 : 4'd1);
    nslots = k;
    nhalf  = !sync_mode && (stop_sel == 2'b10) && (rate_sel != 2'b01);
  end

  assign slot_end  = txc_fall & run & (cnt == '0);
  assign last_slot = (slots_left == 4'd0);
  assign do_load   = nxt_ok & ((slot_end & last_slot) | ~sh_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full   <= 1'b0;
      buf_q      <= '0;
      sh_full    <= 1'b0;
      run        <= 1'b0;
      sh_fill    <= 1'b0;
      sync2_due  <= 1'b0;
      half_last  <= 1'b0;
      frm        <= '1;
      slots_left <= '0;
      cnt        <= '0;
    end else begin
      if (wr_stb && !buf_full) begin
        buf_full <= 1'b1;
        buf_q    <= wr_data;
      end
      if (do_load) begin
        frm        <= nf;
        slots_left <= nslots - 4'd1;
        half_last  <= nhalf;
        sh_full    <= 1'b1;
        sh_fill    <= take_fill;
        cnt        <= per_m1;
        if (take_data) buf_full <= 1'b0;
        if (take_fill) sync2_due <= ~sync2_due & ~single_sync;
      end else if (slot_end && last_slot) begin
        run     <= 1'b0;
        sh_full <= 1'b0;
        sh_fill <= 1'b0;
      end else if (slot_end) begin
        frm        <= {1'b1, frm[FW-1:1]};
        slots_left <= slots_left - 4'd1;
        cnt        <= (slots_left == 4'd1 && half_last) ? half_m1 : per_m1;
      end else if (txc_fall && run) begin
        cnt <= cnt - 1'b1;
      end else if (txc_fall && sh_full) begin
        run <= 1'b1;
        cnt <= per_m1;
      end
    end
  end

  assign txd      = run ? frm[0] : ~brk;
  assign tx_rdy   = ~buf_full;
  assign tx_empty = ~buf_full & ~(sh_full & ~sh_fill);

  // R6
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_rdy) |=> !tx_rdy);

  // R6
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_rdy);

  // R6
  empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(wr_stb));

  // R12
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(txc_fall) && $stable(brk)) |-> $stable(txd));

endmodule

// File: tb/ser_tx_engine_tb_top.sv
`timescale 1ns/1ps
module ser_tx_engine_tb_top;

  typedef struct packed {
    logic       lvl;
    logic       last;
    logic [7:0] tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txc_fall = 1'b0;
  logic [1:0] rate_sel = 2'b10, wlen_sel = 2'b11, stop_sel = 2'b01;
  logic par_en = 1'b0, par_even = 1'b0, single_sync = 1'b0;
  logic tx_en = 1'b1, cts_n = 1'b0, brk = 1'b0;
  logic [7:0] sync1 = 8'h16, sync2 = 8'h3C;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, tx_rdy, tx_empty;

  int checks = 0, fails = 0;
  item_t q[$];
  logic tick_d = 1'b0;
  logic in_frame = 1'b0, arm = 1'b0, allow_low = 1'b0, r12_on = 1'b0;
  logic last_txd = 1'b1;

  always #2.5 clk = ~clk;

  ser_tx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .txc_fall(txc_fall), .rate_sel(rate_sel),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_even(par_even),
    .stop_sel(stop_sel), .single_sync(single_sync), .tx_en(tx_en),
    .cts_n(cts_n), .brk(brk), .sync1(sync1), .sync2(sync2),
    .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd), .tx_rdy(tx_rdy),
    .tx_empty(tx_empty)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      txc_fall = 1'b1;
      @(negedge clk);
      txc_fall = 1'b0;
    end
  end

  always @(posedge clk) tick_d <= txc_fall;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected level per tick
  always @(negedge clk) begin
    if (tick_d) begin
      if (!in_frame && (arm || (q.size() > 0 && txd === 1'b0))) begin
        in_frame = 1'b1;
        arm = 1'b0;
      end
      if (in_frame) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (txd !== it.lvl) begin
          fails++;
          $display("FAIL R%0d txd actual=%b expected=%b", it.tag, txd, it.lvl);
        end
        if (it.last) in_frame = 1'b0;
      end else if (txd !== 1'b1 && !allow_low) begin
        checks++;
        fails++;
        $display("FAIL R8 unexpected txd actual=%b expected=1", txd);
      end
      last_txd = txd;
    end else if (r12_on) begin
      // R12: no change between ticks
      checks++;
      if (txd !== last_txd) begin
        fails++;
        $display("FAIL R12 txd actual=%b expected=%b", txd, last_txd);
      end
    end
  end

  task automatic add_bits(input logic v, input int n, input int tag);
    for (int i = 0; i < n; i++) q.push_back('{lvl: v, last: 1'b0, tag: 8'(tag)});
  endtask

  task automatic push_frame(input logic [7:0] d, input int wl, input bit pe, input bit ev,
                            input logic [1:0] st, input int per, input bit is_sync,
                            input bit mark_last, input int tag);
    logic p;
    item_t it;
    p = 1'b0;
    for (int i = 0; i < wl; i++) p = p ^ d[i];
    if (!ev) p = ~p;
    if (!is_sync) add_bits(1'b0, per, tag);
    for (int i = 0; i < wl; i++) add_bits(d[i], per, tag);
    if (pe) add_bits(p, per, tag);
    if (!is_sync) begin
      if (st == 2'b11 || (st == 2'b10 && per == 1)) begin
        add_bits(1'b1, per, tag);
        add_bits(1'b1, per, tag);
      end else if (st == 2'b10) begin
        add_bits(1'b1, per, tag);
        add_bits(1'b1, per / 2, tag);
      end else begin
        add_bits(1'b1, per, tag);
      end
    end
    if (mark_last) begin
      it = q[$];
      void'(q.pop_back());
      it.last = 1'b1;
      q.push_back(it);
    end
  endtask

  task automatic idle_slot();
    @(negedge clk);
    while (!tick_d) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!tick_d) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_stb = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (q.size() != 0 || in_frame);
    wait_ticks(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic seen_low;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(tx_rdy === 1'b1, "R1 tx_rdy", tx_rdy, 1);
    chk(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
    rst_n = 1'b1;
    chk(txd === 1'b1 && tx_rdy === 1'b1 && tx_empty === 1'b1, "R1 after release", {txd, tx_rdy, tx_empty}, 3'b111);

    // R2, R5, R6: 16 ticks per bit, 8 data bits, no parity, 1 stop
    idle_slot();
    r12_on = 1'b1;
    push_frame(8'hA5, 8, 0, 0, 2'b01, 16, 0, 1, 2);
    wr(8'hA5);
    chk(tx_rdy === 1'b0, "R6 tx_rdy after write", tx_rdy, 0);
    chk(tx_empty === 1'b0, "R6 tx_empty after write", tx_empty, 0);
    @(negedge clk);
    chk(tx_rdy === 1'b1, "R5 immediate transfer", tx_rdy, 1);
    chk(tx_empty === 1'b0, "R6 tx_empty in flight", tx_empty, 0);
    @(negedge clk);
    while (!tick_d) @(negedge clk);
    chk(txd === 1'b0, "R5 start at first tick", txd, 0);
    wait_done();
    chk(tx_empty === 1'b1, "R6 tx_empty after frame", tx_empty, 1);

    // R3, R5, R7: 1 tick per bit, 7 bits, odd parity, 2 stops, back-to-back
    idle_slot();
    rate_sel = 2'b01; wlen_sel = 2'b10; par_en = 1'b1; par_even = 1'b0; stop_sel = 2'b11;
    push_frame(8'h4D, 7, 1, 0, 2'b11, 1, 0, 0, 3);
    push_frame(8'h32, 7, 1, 0, 2'b11, 1, 0, 1, 5);
    wr(8'h4D);
    while (!tx_rdy) @(negedge clk);
    wr(8'h32);
    wr(8'h7F);
    chk(tx_rdy === 1'b0, "R7 buffer stays full", tx_rdy, 0);
    wait_done();
    wait_ticks(20);
    chk(q.size() == 0 && txd === 1'b1 && tx_empty === 1'b1, "R7 dropped byte not sent", txd, 1);
    r12_on = 1'b0;

    // R2, R3, R4: 64 ticks per bit, 5 bits, even parity, 1.5 stops
    idle_slot();
    rate_sel = 2'b11; wlen_sel = 2'b00; par_en = 1'b1; par_even = 1'b1; stop_sel = 2'b10;
    push_frame(8'h13, 5, 1, 1, 2'b10, 64, 0, 1, 4);
    wr(8'h13);
    wait_done();
    // R4: 16 ticks, 6 bits, 1.5 stops (last lasts 8)
    idle_slot();
    rate_sel = 2'b10; wlen_sel = 2'b01; par_en = 1'b0;
    push_frame(8'h2A, 6, 0, 0, 2'b10, 16, 0, 1, 4);
    wr(8'h2A);
    wait_done();
    // R4: 1.5 at one tick per bit becomes 2
    idle_slot();
    rate_sel = 2'b01; wlen_sel = 2'b11;
    push_frame(8'hC3, 8, 0, 0, 2'b10, 1, 0, 1, 4);
    wr(8'hC3);
    wait_done();
    // R4: code 00 as one stop
    idle_slot();
    stop_sel = 2'b00;
    push_frame(8'h81, 8, 0, 0, 2'b00, 1, 0, 1, 4);
    wr(8'h81);
    wait_done();

    // R8: clear-to-send and enable gating
    idle_slot();
    rate_sel = 2'b10; stop_sel = 2'b01; cts_n = 1'b1;
    push_frame(8'h5A, 8, 0, 0, 2'b01, 16, 0, 1, 8);
    wr(8'h5A);
    seen_low = 1'b0;
    for (int i = 0; i < 40; i++) begin
      wait_ticks(1);
      if (txd !== 1'b1) seen_low = 1'b1;
    end
    chk(!seen_low, "R8 line idle while cts_n high", seen_low, 0);
    chk(tx_rdy === 1'b0, "R8 byte held", tx_rdy, 0);
    idle_slot();
    tx_en = 1'b0; cts_n = 1'b0;
    wait_ticks(10);
    chk(txd === 1'b1 && tx_rdy === 1'b0, "R8 held while disabled", {txd, tx_rdy}, 2'b10);
    idle_slot();
    tx_en = 1'b1;
    wait_done();

    // R9: break completes current character, then holds line low
    idle_slot();
    push_frame(8'hF0, 8, 0, 0, 2'b01, 16, 0, 1, 9);
    wr(8'hF0);
    do @(negedge clk); while (txd !== 1'b0);
    wait_ticks(3);
    idle_slot();
    brk = 1'b1;
    allow_low = 1'b1;
    wr(8'h0F);
    do @(negedge clk); while (q.size() != 0 || in_frame);
    wait_ticks(10);
    chk(txd === 1'b0, "R9 line low in break", txd, 0);
    chk(tx_rdy === 1'b0, "R9 buffered byte waits", tx_rdy, 0);
    idle_slot();
    brk = 1'b0;
    allow_low = 1'b0;
    push_frame(8'h0F, 8, 0, 0, 2'b01, 16, 0, 1, 9);
    wait_done();

    // R10, R11: synchronous framing with two sync characters
    idle_slot();
    tx_en = 1'b0; rate_sel = 2'b00; wlen_sel = 2'b11; par_en = 1'b1; par_even = 1'b1;
    single_sync = 1'b0;
    wr(8'h96);
    push_frame(8'h96, 8, 1, 1, 2'b01, 1, 1, 0, 10);
    push_frame(8'h16, 8, 1, 1, 2'b01, 1, 1, 0, 11);
    push_frame(8'h3C, 8, 1, 1, 2'b01, 1, 1, 1, 11);
    idle_slot();
    arm = 1'b1;
    tx_en = 1'b1;
    wait_ticks(12);
    chk(tx_empty === 1'b1, "R11 tx_empty during fill", tx_empty, 1);
    wait_ticks(9);
    idle_slot();
    tx_en = 1'b0;
    wait_done();
    chk(txd === 1'b1, "R10 idle after disable", txd, 1);

    // R11: single sync character fill
    idle_slot();
    single_sync = 1'b1;
    wr(8'h3B);
    push_frame(8'h3B, 8, 1, 1, 2'b01, 1, 1, 0, 10);
    push_frame(8'h16, 8, 1, 1, 2'b01, 1, 1, 0, 11);
    push_frame(8'h16, 8, 1, 1, 2'b01, 1, 1, 1, 11);
    idle_slot();
    arm = 1'b1;
    tx_en = 1'b1;
    wait_ticks(21);
    idle_slot();
    tx_en = 1'b0;
    wait_done();
    chk(tx_empty === 1'b1 && txd === 1'b1, "R11 idle after single fill", {tx_empty, txd}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule